// File: doc/BRIEF.md
# Chip-Enable Gate with Bounded Completion Hold

This block sits between a processor's active-low memory chip-enable and a RAM that must survive a supply failure. In normal running the gated enable follows the processor's enable one clock later. When the supervisor raises its reset flag, the gate looks at the enable at that moment. If no access is under way, the RAM is shut off for the whole reset event. If an access is under way, the gate lets it run on, but only for a bounded time. The hold stops early if the processor releases the enable first. After that the RAM stays shut off until reset drops.

A battery-backup flag overrides everything else: while it is high the gated enable is inactive and the processor's enable is ignored. The hold length is given in nanoseconds and turned into a cycle count from the clock frequency, so the same code serves any clock. Sequencing is done by a three-state machine (pass, hold-low, blocked) with a separate hold timer. The output is a single register.

Top module: `cegate_top`

## Requirements
- R1: While `rst` is high at a clock edge, `ce_out_n` is 1 after that edge, and the machine restarts in pass mode.
- R2: When `sup_reset` and `batt_mode` are both 0 at an edge, `ce_out_n` after that edge equals `ce_in_n` sampled at that edge (one cycle of latency).
- R3: If `ce_in_n` is 1 at the first edge where `sup_reset` is seen high (coming from pass mode), `ce_out_n` is 1 for the whole reset event, whatever `ce_in_n` does.
- R4: If `ce_in_n` is 0 at the first edge where `sup_reset` is seen high and stays 0, `ce_out_n` is 0 for exactly HOLD_CYCLES cycles and then goes to 1 (600 cycles at the default 50 MHz and 12000 ns).
- R5: During the hold, an edge that samples `ce_in_n` at 1 ends the hold, and `ce_out_n` is 1 after that edge.
- R6: Once the output is 1 during a reset event, it stays 1 until `sup_reset` is sampled low, and `ce_in_n` transitions have no effect.
- R7: While `batt_mode` is 1 at an edge, `ce_out_n` is 1 after that edge and `ce_in_n` is ignored. A reset arriving together with battery mode blocks at once and starts no hold.
- R8: The first edge that samples `sup_reset` at 0 (with `batt_mode` at 0) returns the gate to following `ce_in_n`. This holds even if the release comes in the middle of a hold.
- R9: Outside `rst`, `ce_out_n` is 0 only if `ce_in_n` was 0 at the edge that produced it.
- R10: No run of low output cycles produced under `sup_reset` is longer than HOLD_CYCLES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_reset | input | 1 | Supervisor reset flag, high while the system is held in reset |
| batt_mode | input | 1 | High while running from the backup battery |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| ce_out_n | output | 1 | Gated active-low chip-enable to the RAM, registered |

## Verification
The properties assume that `sup_reset`, `batt_mode` and `ce_in_n` are already synchronous to `clk`. They also assume these inputs change only between edges, so each edge sees one stable value. The bench drives every input on the falling edge and reads `ce_out_n` on the next falling edge. This keeps sampling clean and lets each expected value come directly from the inputs of the edge in between. The checker's hold-length bound counts low output cycles from the port side. It does not depend on the internal timer reaching its own limit.

// File: rtl/cegate_pkg.sv
`timescale 1ns/1ps
package cegate_pkg;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_BLOCK = 2'd2
  } gate_state_e;

  // Convert a hold time in ns into clock cycles, never below one.
  function automatic int unsigned hold_cycles(input int unsigned clk_hz,
                                              input int unsigned hold_ns);
    int unsigned mhz;
    int unsigned cyc;
    mhz = clk_hz / 1_000_000;
    cyc = (mhz * hold_ns) / 1000;
    return (cyc < 1) ? 1 : cyc;
  endfunction

endpackage

// File: rtl/cegate_hold_timer.sv
`timescale 1ns/1ps
module cegate_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int unsigned CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // cnt_q holds the number of hold cycles already spent beyond the first.
  assign expired = (cnt_q == LAST);

endmodule

// File: rtl/cegate_seq.sv
`timescale 1ns/1ps
module cegate_seq
  import cegate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sup_reset,
  input  logic        batt_mode,
  input  logic        ce_in_n,
  input  logic        hold_expired,
  output gate_state_e state_q,
  output gate_state_e state_d,
  output logic        timer_start,
  output logic        timer_run
);

  always_comb begin
    state_d = state_q;
    if (batt_mode) begin
      state_d = ST_BLOCK;
    end else begin
      unique case (state_q)
        ST_PASS: begin
          if (sup_reset) state_d = ce_in_n ? ST_BLOCK : ST_HOLD;
        end
        ST_HOLD: begin
          if (!sup_reset)                 state_d = ST_PASS;
          else if (ce_in_n || hold_expired) state_d = ST_BLOCK;
        end
        ST_BLOCK: begin
          if (!sup_reset) state_d = ST_PASS;
        end
        default: state_d = ST_BLOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PASS;
    else     state_q <= state_d;
  end

  assign timer_start = (state_q != ST_HOLD) && (state_d == ST_HOLD);
  assign timer_run   = (state_q == ST_HOLD);

endmodule

// File: rtl/cegate_drive.sv
`timescale 1ns/1ps
module cegate_drive
  import cegate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  gate_state_e state_d,
  input  logic        ce_in_n,
  output logic        ce_out_n
);
  logic drive_d;

  always_comb begin
    unique case (state_d)
      ST_PASS: drive_d = ce_in_n;
      ST_HOLD: drive_d = 1'b0;
      default: drive_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ce_out_n <= 1'b1;
    else     ce_out_n <= drive_d;
  end

endmodule

// File: rtl/cegate_top.sv
`timescale 1ns/1ps
module cegate_top
  import cegate_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned HOLD_NS     = 12_000
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_reset,
  input  logic batt_mode,
  input  logic ce_in_n,
  output logic ce_out_n
);
  localparam int unsigned HOLD_CYCLES = hold_cycles(CLK_FREQ_HZ, HOLD_NS);

  gate_state_e state_q;
  gate_state_e state_d;
  logic        timer_start;
  logic        timer_run;
  logic        hold_expired;

  cegate_seq seq_i (
    .clk         (clk),
    .rst         (rst),
    .sup_reset   (sup_reset),
    .batt_mode   (batt_mode),
    .ce_in_n     (ce_in_n),
    .hold_expired(hold_expired),
    .state_q     (state_q),
    .state_d     (state_d),
    .timer_start (timer_start),
    .timer_run   (timer_run)
  );

  cegate_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .start  (timer_start),
    .run    (timer_run),
    .expired(hold_expired)
  );

  cegate_drive drive_i (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .ce_in_n (ce_in_n),
    .ce_out_n(ce_out_n)
  );

endmodule

// File: rtl/cegate_top_chk.sv
`timescale 1ns/1ps
module cegate_top_chk #(
  parameter int unsigned HOLD_CYCLES = 600
) (
  input logic clk,
  input logic rst,
  input logic sup_reset,
  input logic batt_mode,
  input logic ce_in_n,
  input logic ce_out_n
);
  logic        prev_sup;
  logic        prev_rst;
  int unsigned low_run;

  always_ff @(posedge clk) begin
    prev_sup <= sup_reset;
    prev_rst <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst)                                       low_run <= 0;
    else if (!ce_out_n && prev_sup && !prev_rst)   low_run <= low_run + 1;
    else                                           low_run <= 0;
  end

  AST_RESET_HIGH: assert property (@(posedge clk)
    rst |=> ce_out_n);                                                  // R1

  AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!sup_reset && !batt_mode) |=> (ce_out_n == $past(ce_in_n)));       // R2

  AST_RELEASE_ENDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sup_reset && ce_in_n) |=> ce_out_n);                               // R5

  AST_STAY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (sup_reset && $past(sup_reset) && !$past(rst) && ce_out_n) |=> ce_out_n); // R6

  AST_BATT_HIGH: assert property (@(posedge clk) disable iff (rst)
    batt_mode |=> ce_out_n);                                            // R7

  AST_LOW_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    (!ce_out_n && !$past(rst)) |-> !$past(ce_in_n));                    // R9

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    low_run <= HOLD_CYCLES);                                            // R10

endmodule

bind cegate_top cegate_top_chk #(
  .HOLD_CYCLES(HOLD_CYCLES)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .sup_reset(sup_reset),
  .batt_mode(batt_mode),
  .ce_in_n  (ce_in_n),
  .ce_out_n (ce_out_n)
);

// File: tb/cegate_top_tb_top.sv
`timescale 1ns/1ps
module cegate_top_tb_top;

  localparam int HOLD = 600;  // 12000 ns at 50 MHz
  localparam int NVEC = 18;

  // {req id, rst, sup_reset, batt_mode, ce_in_n, expected ce_out_n}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R1
    {4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R1
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R2
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 reset seen with ce high
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R3
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R3
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R3
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 release
    {4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 battery alone
    {4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R7
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R8
    {4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R7 battery with reset: no hold
    {4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 still blocked
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R2
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2
    {4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}   // R1 reset mid-run
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_reset = 1'b0;
  logic batt_mode = 1'b0;
  logic ce_in_n = 1'b1;
  logic ce_out_n;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cegate_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .sup_reset(sup_reset),
    .batt_mode(batt_mode),
    .ce_in_n  (ce_in_n),
    .ce_out_n (ce_out_n)
  );

  task automatic step(input logic r, input logic s, input logic b, input logic c);
    rst = r; sup_reset = s; batt_mode = b; ce_in_n = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    tests++;
    if (ce_out_n !== exp) begin
      fails++;
      $display("FAIL %s: ce_out_n=%b expected %b", req, ce_out_n, exp);
    end
  endtask

  initial begin
    #(200_000 * 20);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int low_cnt;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      tests++;
      if (ce_out_n !== VEC[i][0]) begin
        fails++;
        $display("FAIL R%0d vector %0d: ce_out_n=%b expected %b",
                 VEC[i][8:5], i, ce_out_n, VEC[i][0]);
      end
    end

    // R4: full-length hold with ce_in_n held low
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", 1'b0);
    low_cnt = 0;
    for (int k = 0; k < HOLD + 50; k++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      if (ce_out_n === 1'b0) low_cnt++;
    end
    tests++;
    if (low_cnt != HOLD) begin
      fails++;
      $display("FAIL R4: low cycles=%0d expected %0d", low_cnt, HOLD);
    end
    check("R4", 1'b1);
    // R6: toggles after the hold have no effect
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b1, 1'b0, k[0]);
      check("R6", 1'b1);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", 1'b0);

    // R5: early end of hold when ce_in_n rises
    step(1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", 1'b0);
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    check("R5", 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    check("R6", 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8", 1'b1);

    // R8: release during hold resumes following
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8", 1'b1);

    // R7: battery during hold forces high
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    check("R7", 1'b1);

    // R1: synchronous reset during a hold
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R1", 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R1", 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule